// File: doc/BRIEF.md
# ADC Input Signal Power Monitor

This block watches a stream of signed ADC samples, one per clock, and condenses each measurement window into a single 24-bit statistic. Three statistics are available: the largest sample magnitude, a scaled sum of squared magnitudes that serves as a mean power figure, and the number of samples whose magnitude rises above a programmable upper threshold. A per-cycle magnitude is formed by stripping the sign from each sample, so -1024 counts as 1024.

The window length is a 24-bit count of clock cycles. At the end of every window the result lands in a read-only holding register, and a one-cycle interrupt pulse marks the update. The period timer can be switched off instead. The holding register then updates only when software reads it, and it can optionally restart the accumulation on each such read. Configuration arrives as plain inputs: enable, a 2-bit mode, clear-on-read, timer-off, period and threshold.

Top module: `adc_power_monitor`

## Requirements
- R1: After reset `hold_value` is 0 and `irq` is 0.
- R2: With the timer in control, a window holds exactly P samples, where P is `cfg_period`, and a period of 0 acts as 1. The holding register takes the result at the clock edge that accepts the first sample of the next window, and `irq` is high for exactly the one cycle after that edge. There is one pulse per window.
- R3: Mode 2'b00 (peak) reports the largest sample magnitude in the window. The magnitude of the most negative code -1024 is 1024.
- R4: Mode 2'b10 (crossing count) reports how many samples in the window have a magnitude strictly greater than `cfg_upper_thr`. A magnitude equal to the threshold is not counted.
- R5: Mode 2'b01 (mean power) reports the window's sum of squared magnitudes shifted right by `MEAN_SHIFT` (8). Results above 0xFFFFFF saturate to 0xFFFFFF.
- R6: Mode 2'b11 is invalid. While it is selected with enable high, the accumulator stays empty, `hold_value` does not change and `irq` stays low.
- R7: While `cfg_enable` is 0 the block is idle whatever the mode bits hold. `hold_value` is kept and `irq` stays low. After enable rises, a fresh window starts with the first enabled sample.
- R8: With `cfg_timer_off` high, no periodic update and no `irq` occur. A clock edge with `rd_strobe` high copies into `hold_value` the statistic of the samples taken since the last restart. The sample taken on that same edge is not included.
- R9: With `cfg_timer_off` and `cfg_clear_on_read` both high, the sample taken on a read edge begins a new accumulation. With clear-on-read low, accumulation continues across reads.
- R10: With the timer in control, `rd_strobe` and `cfg_clear_on_read` have no effect on `hold_value` or on the window results.
- R11: The sample taken on a window-boundary edge belongs to the new window, not to the one just reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_sample | input | 11 | Signed two's-complement sample, one per clock |
| cfg_enable | input | 1 | Monitor enable |
| cfg_mode | input | 2 | 00 peak, 01 mean power, 10 crossing count, 11 invalid |
| cfg_clear_on_read | input | 1 | Restart accumulation on a read (timer-off only) |
| cfg_timer_off | input | 1 | Reads instead of the period timer drive updates |
| cfg_period | input | 24 | Window length in clock cycles (0 acts as 1) |
| cfg_upper_thr | input | 10 | Upper magnitude threshold for crossing count |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| hold_value | output | 24 | Holding register with the latest statistic |
| irq | output | 1 | One-cycle pulse on each timer-driven update |

## Verification
A read strobe and a window boundary can land on the same clock edge while the timer is in control, and clear-on-read is set at the same time. A scoreboard burst keeps clear-on-read high and pulses `rd_strobe` every third sample, so some pulses coincide with boundary edges and others fall mid-window. Each window result is compared with a value computed from the samples alone. After every mid-window read the bench confirms that `hold_value` did not move. A second coincidence is a boundary sample that starts the new window on the same edge that reports the old one. A spike placed on exactly that sample must appear in the second window's peak and not in the first.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    MODE_PEAK   = 2'b00,
    MODE_MEAN   = 2'b01,
    MODE_XCOUNT = 2'b10,
    MODE_BAD    = 2'b11
  } pm_mode_e;
endpackage

// File: rtl/pm_window_timer.sv
module pm_window_timer #(
  parameter int PERIOD_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] cfg_period,
  output logic                window_end
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] eff_period;

  // a zero period behaves as a one-cycle window
  assign eff_period = (cfg_period == '0) ? PERIOD_W'(1) : cfg_period;
  // cnt_q holds the number of samples already in the current window
  assign window_end = run && (cnt_q >= eff_period);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (window_end) cnt_q <= PERIOD_W'(1);
    else                 cnt_q <= cnt_q + PERIOD_W'(1);
  end

  // R11: the boundary sample is the first one of the new window
  a_r11_boundary_restart: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> (cnt_q <= PERIOD_W'(1)));
endmodule

// File: rtl/pm_stat_accum.sv
module pm_stat_accum import pm_pkg::*; #(
  parameter int SAMPLE_W   = 11,
  parameter int THR_W      = 10,
  parameter int ACC_W      = 48,
  parameter int OUT_W      = 24,
  parameter int MEAN_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  pm_mode_e            mode,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [THR_W-1:0]    thr,
  input  logic                restart,
  output logic [OUT_W-1:0]    stat_now
);
  localparam int MAG_W = SAMPLE_W;
  localparam int SQ_W  = 2 * MAG_W;

  function automatic logic [MAG_W-1:0] f_mag(input logic [SAMPLE_W-1:0] s);
    return s[SAMPLE_W-1] ? MAG_W'(-s) : MAG_W'(s);
  endfunction

  function automatic logic [ACC_W-1:0] f_contrib(input logic [MAG_W-1:0] m,
                                                 input pm_mode_e md,
                                                 input logic [THR_W-1:0] t);
    case (md)
      MODE_PEAK:   return ACC_W'(m);
      MODE_MEAN:   return ACC_W'(SQ_W'(m) * SQ_W'(m));
      MODE_XCOUNT: return ACC_W'(m > MAG_W'(t));
      default:     return '0;
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] f_merge(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] c,
                                               input pm_mode_e md);
    logic [ACC_W:0] sum;
    if (md == MODE_PEAK) return (c > a) ? c : a;
    sum = {1'b0, a} + {1'b0, c};
    return sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  endfunction

  function automatic logic [OUT_W-1:0] f_finalize(input logic [ACC_W-1:0] a,
                                                  input pm_mode_e md);
    logic [ACC_W-1:0] v;
    v = (md == MODE_MEAN) ? (a >> MEAN_SHIFT) : a;
    return (|v[ACC_W-1:OUT_W]) ? '1 : v[OUT_W-1:0];
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [MAG_W-1:0] sample_mag;
  logic [ACC_W-1:0] contrib;
  logic [ACC_W-1:0] merged;

  assign sample_mag = f_mag(sample);
  assign contrib    = f_contrib(sample_mag, mode, thr);
  assign merged     = f_merge(acc_q, contrib, mode);
  assign stat_now   = f_finalize(acc_q, mode);

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (!active) acc_q <= '0;
    else if (restart) acc_q <= contrib;
    else              acc_q <= merged;
  end

  // R6 / R7: an idle or invalid-mode monitor keeps an empty accumulator
  a_r6_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (acc_q == '0));
  // R3: within a window the peak never falls
  a_r3_peak_nondecreasing: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == MODE_PEAK && !restart) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/adc_power_monitor.sv
module adc_power_monitor import pm_pkg::*; #(
  parameter int SAMPLE_W   = 11,
  parameter int THR_W      = 10,
  parameter int PERIOD_W   = 24,
  parameter int OUT_W      = 24,
  parameter int ACC_W      = 48,
  parameter int MEAN_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] adc_sample,
  input  logic                cfg_enable,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_clear_on_read,
  input  logic                cfg_timer_off,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [THR_W-1:0]    cfg_upper_thr,
  input  logic                rd_strobe,
  output logic [OUT_W-1:0]    hold_value,
  output logic                irq
);
  pm_mode_e         mode;
  logic             active;
  logic             timer_run;
  logic             window_end;
  logic             read_update;
  logic             read_clear;
  logic             restart;
  logic [OUT_W-1:0] stat_now;

  assign mode        = pm_mode_e'(cfg_mode);
  assign active      = cfg_enable && (mode != MODE_BAD);
  assign timer_run   = active && !cfg_timer_off;
  assign read_update = active && cfg_timer_off && rd_strobe;
  assign read_clear  = read_update && cfg_clear_on_read;
  assign restart     = window_end || read_clear;

  pm_window_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (timer_run),
    .cfg_period (cfg_period),
    .window_end (window_end)
  );

  pm_stat_accum #(
    .SAMPLE_W   (SAMPLE_W),
    .THR_W      (THR_W),
    .ACC_W      (ACC_W),
    .OUT_W      (OUT_W),
    .MEAN_SHIFT (MEAN_SHIFT)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .mode     (mode),
    .sample   (adc_sample),
    .thr      (cfg_upper_thr),
    .restart  (restart),
    .stat_now (stat_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_value <= '0;
      irq        <= 1'b0;
    end else begin
      irq <= window_end;
      if (window_end || read_update) hold_value <= stat_now;
    end
  end

  // R7: a disabled monitor leaves the holding register alone
  a_r7_idle_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> $stable(hold_value));
  // R2: an interrupt follows only a cycle where the timer was in control
  a_r2_irq_timer_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cfg_enable && !cfg_timer_off && cfg_mode != 2'b11));
  // R8: read-driven operation never raises the interrupt
  a_r8_no_irq_when_timer_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_timer_off |=> !irq);
  // R6: the invalid mode is silent
  a_r6_bad_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_mode == 2'b11) |=> (!irq && $stable(hold_value)));
endmodule

// File: tb/adc_power_monitor_bench.sv
module adc_power_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] smp = '0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        clr = 1'b0;
  logic        toff = 1'b0;
  logic [23:0] per = 24'd1;
  logic [9:0]  thr = 10'd0;
  logic        rd = 1'b0;
  logic [23:0] hold;
  logic        irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    irq_seen = 0;
  int    exp_q[$];
  string cur_tag = "R2";
  bit    done = 0;

  always #5 clk = ~clk;

  adc_power_monitor u_adc_power_monitor (
    .clk(clk), .rst_n(rst_n), .adc_sample(smp), .cfg_enable(en), .cfg_mode(mode),
    .cfg_clear_on_read(clr), .cfg_timer_off(toff), .cfg_period(per),
    .cfg_upper_thr(thr), .rd_strobe(rd), .hold_value(hold), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(input int kind, input int i, input int p);
    case (kind)
      0: return ((i * 37 + 5) % 2047) - 1023;
      1: return (i == 3) ? -1024 : (i % 7) * 50;
      2: case (i % 4) 0: return 500; 1: return -500; 2: return 501; default: return -502; endcase
      3: return -1024;
      default: return (i == p) ? 900 : i + 1;
    endcase
  endfunction

  // monitor: every interrupt pops one expected window result
  always @(negedge clk) begin
    if (rst_n && irq) begin
      irq_seen++;
      if (exp_q.size() == 0) chk(0, {cur_tag, " unexpected irq"}, hold, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(hold == 24'(e), cur_tag, hold, e);
      end
    end
  end

  // driver: computes each window's expected result and pushes it, then feeds samples
  task automatic timer_burst(input int md, input int p, input int nwin, input int kind,
                             input int th, input bit rd_pulses, input string tag);
    int pe, base;
    logic [23:0] prev;
    pe = (p == 0) ? 1 : p;
    cur_tag = tag;
    mode = 2'(md); per = 24'(p); thr = 10'(th); toff = 0; clr = rd_pulses;
    for (int w = 0; w < nwin; w++) begin
      longint acc;
      acc = 0;
      for (int j = 0; j < pe; j++) begin
        int s, m;
        s = gen(kind, w * pe + j, pe);
        m = (s < 0) ? -s : s;
        if (md == 0) acc = (m > acc) ? m : acc;
        else if (md == 1) acc += longint'(m) * m;
        else if (m > th) acc++;
      end
      if (md == 1) begin
        acc = acc >>> 8;
        if (acc > 64'hFFFFFF) acc = 64'hFFFFFF;
      end
      exp_q.push_back(int'(acc));
    end
    base = irq_seen;
    en = 1;
    for (int i = 0; i <= nwin * pe; i++) begin
      smp = 11'(gen(kind, i, pe));
      rd  = rd_pulses && (i % 3 == 1);
      prev = hold;
      @(negedge clk);
      if (rd && (i % pe != 0))
        chk(hold == prev, "R10 read in timer mode changed hold", hold, prev);
    end
    en = 0; rd = 0;
    @(negedge clk);
    chk(irq_seen - base == nwin, {tag, " R2 irq count"}, irq_seen - base, nwin);
    chk(exp_q.size() == 0, {tag, " R2 missing updates"}, exp_q.size(), 0);
  endtask

  task automatic idle_check(input bit e, input int md, input string tag);
    logic [23:0] h;
    int base;
    h = hold; base = irq_seen; cur_tag = tag;
    en = e; mode = 2'(md); toff = 0; per = 24'd2;
    for (int i = 0; i < 20; i++) begin
      smp = 11'(gen(0, i, 2));
      @(negedge clk);
    end
    en = 0;
    @(negedge clk);
    chk(hold == h, {tag, " hold changed"}, hold, h);
    chk(irq_seen == base, {tag, " irq raised"}, irq_seen - base, 0);
  endtask

  task automatic feed(input int s);
    smp = 11'(s);
    @(negedge clk);
  endtask

  task automatic read_seq(input bit c, input logic [23:0] exp2, input string tag);
    logic [23:0] h0;
    int base;
    cur_tag = tag;
    h0 = hold; base = irq_seen;
    mode = 2'b00; toff = 1; clr = c; per = 24'd2; en = 1;
    feed(10); feed(20); feed(30);
    chk(hold == h0, "R8 periodic update with timer off", hold, h0);
    rd = 1; feed(5); rd = 0;
    chk(hold == 24'd30, "R8 read update excludes read sample", hold, 30);
    feed(7); feed(8);
    rd = 1; feed(1); rd = 0;
    chk(hold == exp2, {tag, " second read"}, hold, exp2);
    chk(irq_seen == base, "R8 irq with timer off", irq_seen - base, 0);
    en = 0; toff = 0; clr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hold == 0, "R1 reset hold", hold, 0);
    chk(irq == 0, "R1 reset irq", irq, 0);

    timer_burst(0, 4, 3, 0, 0, 0, "R3 peak");
    timer_burst(0, 5, 2, 1, 0, 0, "R3 peak -1024");
    timer_burst(2, 6, 3, 2, 500, 0, "R4 crossing count");
    timer_burst(2, 7, 2, 0, 300, 0, "R4 crossing mixed");
    timer_burst(1, 8, 2, 0, 0, 0, "R5 mean");
    timer_burst(1, 5000, 1, 3, 0, 0, "R5 mean saturation");
    timer_burst(0, 0, 4, 0, 0, 0, "R2 period zero");
    timer_burst(0, 1, 3, 0, 0, 0, "R2 period one");
    idle_check(1, 3, "R6 invalid mode");
    idle_check(0, 0, "R7 disabled");
    timer_burst(0, 3, 2, 4, 0, 0, "R11 R7 boundary sample");
    read_seq(1, 24'd8, "R9 clear-on-read");
    read_seq(0, 24'd30, "R9 no clear");
    timer_burst(0, 5, 3, 0, 0, 1, "R10 reads in timer mode");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule